// File: doc/BRIEF.md
# Out-of-Order Writeback Scoreboard

This block keeps track of instructions in flight for a single-issue, in-order core whose execution units have fixed but different latencies, ranging from one cycle to several tens of cycles. Each unit has a result channel with a valid/ready handshake. The block takes a result from any unit in the order the results finish, not in program order. It then writes that result to the register file through one write port.

The issue stage shows the block each instruction before the instruction starts. For each one it gives two source registers, a destination register, a write flag and the ID of the target unit, and the block answers with a stall. The block keeps one busy bit per architectural register. It stalls an instruction that reads a busy register, which is a read-after-write hazard. It also stalls an instruction that would write a busy register, which is a write-after-write hazard. Because of that second rule, a slow older result can never overwrite a newer one.

The writeback path does not depend on the issue path. A result that is waiting for the write port stalls only the instructions that touch its register. When several units finish in the same cycle, the unit with the longest configured latency wins the port. The other units keep their result until they are granted.

Each unit must return its own results in the order they were issued, and the block accepts them in the order they are presented. A flush input clears all busy bits and drains any result that is waiting.

Top module: `wb_scoreboard`

## Requirements
- R1: After reset no register is busy. An issue with any sources and destination is not stalled, no result channel is ready, and the write enable is low.
- R2: An issue whose first or second source register is busy is stalled.
- R3: An issue that writes (write flag 1) a busy destination register is stalled. The same destination with write flag 0 is not stalled by that register.
- R4: Results that are waiting to be written do not stall an issue whose sources and destination are not busy.
- R5: Register index 0 never becomes busy. A result for register 0 is accepted (ready high) but the write enable stays low.
- R6: At most one result is accepted per cycle. Among the units that are valid, the one with the largest configured latency is granted, and ties go to the lowest unit index. With the default latencies (units 0..3 = 1, 3, 6, 29 cycles), unit 3 has the highest priority and unit 0 the lowest. A unit that is not granted sees ready low.
- R7: Results from different units are written in the order they are granted, which can differ from program order.
- R8: A granted result drives the write port in the same cycle (enable, index, data). Its register stops being busy from the next cycle on, and it stays busy until that cycle.
- R9: While flush is high, issue is stalled, the write enable is low and every valid result channel sees ready high, so its result is dropped. From the next cycle on, no register is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear busy state and drop waiting results |
| iss_valid | input | 1 | Issue request present |
| iss_src_a | input | 5 | First source register |
| iss_src_b | input | 5 | Second source register |
| iss_dst | input | 5 | Destination register |
| iss_dst_we | input | 1 | Instruction writes its destination |
| iss_unit | input | 2 | Execution unit that receives the instruction |
| iss_stall | output | 1 | Issue must be held this cycle |
| res_valid | input | 4 | Per-unit result present |
| res_dst | input | 20 | Per-unit result register index, unit u at bits [5u+4:5u] |
| res_data | input | 128 | Per-unit result value, unit u at bits [32u+31:32u] |
| res_ready | output | 4 | Per-unit result accepted this cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The hazard logic is tested with a busy register used in each source slot, as a written destination and as a destination that is not written. This shows that each field is compared with the busy table on its own terms. An unrelated issue is made while a result is waiting, which separates a busy-bit stall from a writeback-caused stall. The arbiter is given three units that are valid in the same cycle and were issued in a program order that differs from their latency order. The resulting write sequence tells latency priority apart from index or arrival order, and it shows that the losing units keep their data. Register 0 results and a flush that lands on a waiting result cover the cases that discard data.

// File: rtl/sb_pkg.sv
// Package: default sizing for the writeback scoreboard.
// Assumes a 32-entry register file with index 0 hard-wired to zero.
package sb_pkg;
    localparam int unsigned SB_NUM_UNITS = 4;
    localparam int unsigned SB_NUM_REGS  = 32;
    localparam int unsigned SB_XLEN      = 32;
    localparam int unsigned SB_MAX_LAT   = 29;
endpackage

// File: rtl/sb_busy_table.sv
// Module: sb_busy_table
// Keeps one busy bit and one owning-unit tag per register. A bit is set
// when an instruction that writes that register issues, and it is cleared
// when the owning unit's result is written. Index 0 is never marked.
// Assumes that set and clear never target the same register in one cycle.
// The issue stall keeps that true, because a busy register cannot be set again.
module sb_busy_table #(
    parameter int unsigned NUM_REGS  = 32,
    parameter int unsigned NUM_UNITS = 4,
    localparam int unsigned RW = $clog2(NUM_REGS),
    localparam int unsigned UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                set_en,
    input  logic [RW-1:0]       set_idx,
    input  logic [UW-1:0]       set_unit,
    input  logic                clr_en,
    input  logic [RW-1:0]       clr_idx,
    input  logic [UW-1:0]       clr_unit,
    input  logic [RW-1:0]       q_src_a,
    input  logic [RW-1:0]       q_src_b,
    input  logic [RW-1:0]       q_dst,
    input  logic                q_dst_we,
    output logic                hit_src,
    output logic                hit_dst,
    output logic [NUM_REGS-1:0] busy_vec
);
    logic [NUM_REGS-1:0] busy_q;
    logic [UW-1:0]       owner_q [NUM_REGS];

    // Update busy bits and owner tags on issue, writeback and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            busy_q <= '0;
            for (int r = 0; r < int'(NUM_REGS); r++) owner_q[r] <= '0;
        end else begin
            if (clr_en && owner_q[clr_idx] == clr_unit) busy_q[clr_idx] <= 1'b0;
            if (set_en && set_idx != '0) begin
                busy_q[set_idx]  <= 1'b1;
                owner_q[set_idx] <= set_unit;
            end
        end
    end

    // Look up the issue operands in the busy table.
    always_comb begin
        hit_src = busy_q[q_src_a] | busy_q[q_src_b];
        hit_dst = q_dst_we & busy_q[q_dst];
    end

    assign busy_vec = busy_q;

    AST_X0_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]); // R5
    AST_CLEAR_MATCHES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !flush) |-> (busy_q[clr_idx] && owner_q[clr_idx] == clr_unit)); // R8
endmodule

// File: rtl/sb_wb_arbiter.sv
// Module: sb_wb_arbiter
// Gives the single register-file write port to one valid result channel.
// The unit with the largest configured latency wins, and on a tie the lower
// index wins. While flushing it grants nothing. Assumes that a unit keeps
// valid and its payload stable until it sees ready.
module sb_wb_arbiter #(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned UNIT_LAT [NUM_UNITS] = '{1, 3, 6, 29},
    localparam int unsigned UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [NUM_UNITS-1:0] req,
    output logic [NUM_UNITS-1:0] grant,
    output logic [UW-1:0]        grant_idx,
    output logic                 grant_any
);
    logic          found;
    logic [UW-1:0] best;
    int unsigned   best_lat;

    // Pick the valid unit that has the longest latency.
    always_comb begin
        found    = 1'b0;
        best     = '0;
        best_lat = 0;
        for (int i = 0; i < int'(NUM_UNITS); i++) begin
            if (req[i] && (!found || UNIT_LAT[i] > best_lat)) begin
                found    = 1'b1;
                best     = UW'(i);
                best_lat = UNIT_LAT[i];
            end
        end
    end

    // Turn the chosen unit into a one-hot grant; grant nothing during a flush.
    always_comb begin
        grant_any = found & ~flush;
        grant_idx = best;
        grant     = '0;
        if (grant_any) grant[best] = 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R6

    for (genvar gi = 0; gi < int'(NUM_UNITS); gi++) begin : g_prio_i
        for (genvar gj = 0; gj < int'(NUM_UNITS); gj++) begin : g_prio_j
            if (UNIT_LAT[gj] > UNIT_LAT[gi]) begin : g_chk
                AST_LONGER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                    grant[gi] |-> !req[gj]); // R6
            end
        end
    end
endmodule

// File: rtl/wb_scoreboard.sv
// Module: wb_scoreboard (top)
// Tracks destination registers that are still in flight for an in-order,
// single-issue core. It stalls issue on RAW and WAW hazards and writes
// completed results from several fixed-latency units through one port, in
// the order they are granted. Assumes that each unit returns its own results
// in issue order and holds a result until ready.
module wb_scoreboard
    import sb_pkg::*;
#(
    parameter int unsigned NUM_UNITS = SB_NUM_UNITS,
    parameter int unsigned NUM_REGS  = SB_NUM_REGS,
    parameter int unsigned XLEN      = SB_XLEN,
    parameter int unsigned UNIT_LAT [NUM_UNITS] = '{1, 3, 6, SB_MAX_LAT},
    localparam int unsigned RW = $clog2(NUM_REGS),
    localparam int unsigned UW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      iss_valid,
    input  logic [RW-1:0]             iss_src_a,
    input  logic [RW-1:0]             iss_src_b,
    input  logic [RW-1:0]             iss_dst,
    input  logic                      iss_dst_we,
    input  logic [UW-1:0]             iss_unit,
    output logic                      iss_stall,
    input  logic [NUM_UNITS-1:0]      res_valid,
    input  logic [NUM_UNITS*RW-1:0]   res_dst,
    input  logic [NUM_UNITS*XLEN-1:0] res_data,
    output logic [NUM_UNITS-1:0]      res_ready,
    output logic                      rf_we,
    output logic [RW-1:0]             rf_waddr,
    output logic [XLEN-1:0]           rf_wdata
);
    logic                 hit_src, hit_dst, iss_fire, clr_en;
    logic [NUM_REGS-1:0]  busy_vec;
    logic [NUM_UNITS-1:0] grant;
    logic [UW-1:0]        grant_idx;
    logic                 grant_any;
    logic [RW-1:0]        sel_dst;
    logic [XLEN-1:0]      sel_data;

    sb_busy_table #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) i_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .set_en   (iss_fire & iss_dst_we),
        .set_idx  (iss_dst),
        .set_unit (iss_unit),
        .clr_en   (clr_en),
        .clr_idx  (sel_dst),
        .clr_unit (grant_idx),
        .q_src_a  (iss_src_a),
        .q_src_b  (iss_src_b),
        .q_dst    (iss_dst),
        .q_dst_we (iss_dst_we),
        .hit_src  (hit_src),
        .hit_dst  (hit_dst),
        .busy_vec (busy_vec)
    );

    sb_wb_arbiter #(.NUM_UNITS(NUM_UNITS), .UNIT_LAT(UNIT_LAT)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .req       (res_valid),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    // Issue side: stall on a hazard or during a flush.
    always_comb begin
        iss_stall = iss_valid & (flush | hit_src | hit_dst);
        iss_fire  = iss_valid & ~iss_stall;
    end

    // Write side: route the granted unit's payload to the write port.
    always_comb begin
        sel_dst   = res_dst[grant_idx*RW +: RW];
        sel_data  = res_data[grant_idx*XLEN +: XLEN];
        clr_en    = grant_any & (sel_dst != '0);
        rf_we     = clr_en;
        rf_waddr  = sel_dst;
        rf_wdata  = sel_data;
        res_ready = flush ? res_valid : grant;
    end

    AST_RAW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (!busy_vec[iss_src_a] && !busy_vec[iss_src_b])); // R2
    AST_WAW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && iss_dst_we) |-> !busy_vec[iss_dst]); // R3
    AST_WB_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy_vec[rf_waddr]); // R8
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $onehot(res_ready)); // R6
    AST_NO_WB_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rf_we); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> busy_vec == '0); // R9
endmodule

// File: tb/test_wb_scoreboard.sv
module test_wb_scoreboard;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic         iss_valid = 1'b0;
    logic [4:0]   iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic         iss_dst_we = 1'b0;
    logic [1:0]   iss_unit = '0;
    logic         iss_stall;
    logic [3:0]   res_valid = '0;
    logic [19:0]  res_dst = '0;
    logic [127:0] res_data = '0;
    logic [3:0]   res_ready;
    logic         rf_we;
    logic [4:0]   rf_waddr;
    logic [31:0]  rf_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wb_scoreboard i_wb_scoreboard (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_dst_we(iss_dst_we), .iss_unit(iss_unit),
        .iss_stall(iss_stall), .res_valid(res_valid), .res_dst(res_dst),
        .res_data(res_data), .res_ready(res_ready), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic set_issue(logic [4:0] a, logic [4:0] b, logic [4:0] d,
                             logic we, logic [1:0] u);
        iss_valid = 1'b1; iss_src_a = a; iss_src_b = b;
        iss_dst = d; iss_dst_we = we; iss_unit = u;
    endtask

    task automatic idle_issue();
        iss_valid = 1'b0; iss_dst_we = 1'b0;
    endtask

    task automatic set_res(int u, logic [4:0] d, logic [31:0] v);
        res_valid[u] = 1'b1;
        res_dst[u*5 +: 5] = d;
        res_data[u*32 +: 32] = v;
    endtask

    task automatic t_reset();
        set_issue(5'd5, 5'd6, 5'd7, 1'b1, 2'd0);
        iss_valid = 1'b0;
        settle();
        chk("R1 ready", res_ready, 4'b0);
        chk("R1 we", rf_we, 1'b0);
        iss_valid = 1'b1;
        settle();
        chk("R1 stall", iss_stall, 1'b0);
        idle_issue();
        step();
    endtask

    task automatic t_hazard();
        set_issue(5'd0, 5'd0, 5'd5, 1'b1, 2'd1); settle();
        chk("R1 first issue", iss_stall, 1'b0);
        step();
        set_issue(5'd5, 5'd1, 5'd9, 1'b1, 2'd0); settle();
        chk("R2 src_a busy", iss_stall, 1'b1);
        set_issue(5'd1, 5'd5, 5'd9, 1'b1, 2'd0); settle();
        chk("R2 src_b busy", iss_stall, 1'b1);
        set_issue(5'd1, 5'd2, 5'd5, 1'b1, 2'd0); settle();
        chk("R3 dst busy", iss_stall, 1'b1);
        set_issue(5'd1, 5'd2, 5'd5, 1'b0, 2'd0); settle();
        chk("R3 dst no write", iss_stall, 1'b0);
        step();
        // Result for r5 is presented together with an unrelated issue.
        set_res(1, 5'd5, 32'hCAFE0005);
        set_issue(5'd7, 5'd8, 5'd6, 1'b1, 2'd0); settle();
        chk("R4 unrelated issue", iss_stall, 1'b0);
        chk("R8 we", rf_we, 1'b1);
        chk("R8 addr", rf_waddr, 5'd5);
        chk("R8 data", rf_wdata, 32'hCAFE0005);
        chk("R8 ready", res_ready, 4'b0010);
        step();
        res_valid = '0;
        set_issue(5'd5, 5'd0, 5'd0, 1'b0, 2'd0); settle();
        chk("R8 cleared next cycle", iss_stall, 1'b0);
        idle_issue();
        set_res(0, 5'd6, 32'h66); settle();
        chk("R8 r6 write", rf_waddr, 5'd6);
        step();
        res_valid = '0;
    endtask

    task automatic t_x0();
        set_issue(5'd0, 5'd0, 5'd0, 1'b1, 2'd2); step();
        set_issue(5'd0, 5'd0, 5'd0, 1'b1, 2'd2); settle();
        chk("R5 x0 not busy", iss_stall, 1'b0);
        idle_issue();
        set_res(2, 5'd0, 32'hDEAD); settle();
        chk("R5 x0 ready", res_ready, 4'b0100);
        chk("R5 x0 no write", rf_we, 1'b0);
        step();
        res_valid = '0;
    endtask

    task automatic t_arb();
        set_issue(5'd0, 5'd0, 5'd10, 1'b1, 2'd0); step();
        set_issue(5'd0, 5'd0, 5'd11, 1'b1, 2'd3); step();
        set_issue(5'd0, 5'd0, 5'd12, 1'b1, 2'd2); step();
        idle_issue();
        set_res(0, 5'd10, 32'hA0);
        set_res(2, 5'd12, 32'hA2);
        set_res(3, 5'd11, 32'hA3);
        settle();
        chk("R6 longest first ready", res_ready, 4'b1000);
        chk("R7 first write r11", rf_waddr, 5'd11);
        chk("R6 data", rf_wdata, 32'hA3);
        step();
        res_valid[3] = 1'b0;
        set_issue(5'd10, 5'd0, 5'd0, 1'b0, 2'd0); settle();
        chk("R8 waiting reg still busy", iss_stall, 1'b1);
        chk("R6 second ready", res_ready, 4'b0100);
        chk("R7 second write r12", rf_waddr, 5'd12);
        step();
        res_valid[2] = 1'b0;
        idle_issue(); settle();
        chk("R7 third write r10", rf_waddr, 5'd10);
        chk("R6 loser held data", rf_wdata, 32'hA0);
        step();
        res_valid = '0;
    endtask

    task automatic t_flush();
        set_issue(5'd0, 5'd0, 5'd20, 1'b1, 2'd1); step();
        set_issue(5'd0, 5'd0, 5'd21, 1'b1, 2'd2); step();
        flush = 1'b1;
        set_res(1, 5'd20, 32'hF20);
        set_issue(5'd0, 5'd0, 5'd22, 1'b1, 2'd0); settle();
        chk("R9 stall in flush", iss_stall, 1'b1);
        chk("R9 no write", rf_we, 1'b0);
        chk("R9 drop ready", res_ready, 4'b0010);
        step();
        flush = 1'b0;
        res_valid = '0;
        set_issue(5'd20, 5'd0, 5'd21, 1'b1, 2'd0); settle();
        chk("R9 busy cleared", iss_stall, 1'b0);
        chk("R9 no write after", rf_we, 1'b0);
        idle_issue();
        step();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_hazard();
        t_x0();
        t_arb();
        t_flush();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule